// File: doc/BRIEF.md
# Two-Word Burst Dual-Port Double-Data-Rate SRAM

This block is an on-chip memory with one read data path and one write data path that share a single address bus. Every address holds a pair of words that always move together as a two-word burst. A single fast clock drives the block, and its edges alternate between two phases. The K phase carries read commands. The K# phase carries write commands. Data moves on both phases, so each port transfers two words per full cycle, and a read and a write can be issued in the same cycle without any bus turnaround.

Commands are sampled through active-low port selects, and the block accepts every one of them. Write data is captured on the two edges that follow a write command. An active-low select for each byte lane masks the write data. Read data comes back through an output register at a fixed latency, with a valid flag on it. The read output is a valid-only stream. It has no ready input and applies no back-pressure: the receiver must take each word in the clock period in which `rvalid` is high. The `k_edge` output tells the surrounding logic which phase the next clock edge belongs to.

Top module: `qdr2_burst_sram`

## Requirements
- R1: While `rst_n` is low, and in the clock period right after its release, `rvalid` is 0, `rdata` is 0 and `k_edge` is 1.
- R2: After reset, `k_edge` toggles every clock period. A value of 1 marks the coming edge as a K edge (read phase). A value of 0 marks it as a K# edge (write phase). The first edge after reset is a K edge.
- R3: A read is accepted only on a K edge with `rd_sel_n` low. If `rd_sel_n` is low on a K# edge, nothing is output.
- R4: A write is accepted only on a K# edge with `wr_sel_n` low. If `wr_sel_n` is low on a K edge, the memory is left unchanged.
- R5: For a write command on edge t, `wdata` sampled at edge t+1 is stored as word 0 of `addr`, and `wdata` sampled at edge t+2 is stored as word 1.
- R6: `bw_n` bit i, active low, enables bits [i*LANE_W+LANE_W-1 : i*LANE_W] of the word sampled on that edge. Lanes whose bit is high keep their old contents.
- R7: For a read command on edge r, `rdata` carries word 0 in the clock period after edge r+3 and word 1 in the period after edge r+4. `rvalid` is high in exactly those periods and low whenever no read is due.
- R8: Reads on consecutive K edges give a gapless `rvalid` stream, with the words in command order and word 0 before word 1.
- R9: A read returns the effect of every write commanded on an earlier edge, including the K# edge just before it. A write commanded on the K# edge right after the read does not affect it.
- R10: A read and a write to independent addresses can be issued in every cycle, back to back, over the shared address bus.
- R11: When neither select is active, `wdata` and `bw_n` are ignored and the memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; each rising edge is one phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_edge | output | 1 | 1 when the coming edge is a K (read) edge |
| addr | input | ADDR_W | Shared address: read address on K edges, write address on K# edges |
| rd_sel_n | input | 1 | Active-low read select, sampled on K edges |
| wr_sel_n | input | 1 | Active-low write select, sampled on K# edges |
| wdata | input | DATA_W | Write data word, sampled on every edge |
| bw_n | input | DATA_W/LANE_W | Active-low byte-lane write enables for the current word |
| rdata | output | DATA_W | Registered read data word |
| rvalid | output | 1 | High in the periods in which `rdata` holds a burst word |

## Verification
The assertions assume a free-running clock and a reset released between edges. This makes the first edge after reset a K edge, so the phase flag and the edge parity stay locked together. They also assume the caller follows `k_edge` when it drives commands and write data. The stimulus follows `k_edge` in the same way: every scenario runs through a cycle routine that first pads to a K edge. That routine then places the read command on the K edge and the write command on the K# edge. It sends the write words on the two edges after the command, and it drives deliberate junk data on edges that carry no write.

// File: rtl/qdr2_pkg.sv
`timescale 1ns/1ps
package qdr2_pkg;
  // Phase of the coming clock edge.
  typedef enum logic {
    PH_KN = 1'b0,
    PH_K  = 1'b1
  } phase_e;

  // Edges between a read command and the edge that registers its first word.
  localparam int unsigned RD_LAT_EDGES = 3;
endpackage

// File: rtl/qdr2_phase.sv
`timescale 1ns/1ps
module qdr2_phase
  import qdr2_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e ph
);
  // The first edge after reset is a read-phase edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_K;
    else        ph <= (ph == PH_K) ? PH_KN : PH_K;
  end
endmodule

// File: rtl/qdr2_wr_path.sv
`timescale 1ns/1ps
module qdr2_wr_path
  import qdr2_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            ph,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_sel_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  bw_n,
  output logic              cap_vld,
  output logic [ADDR_W:0]   cap_idx,
  output logic [DATA_W-1:0] cap_data,
  output logic [LANES-1:0]  cap_be
);
  // Command age: one edge ago (word 0 due now), two edges ago (word 1 due now).
  logic              age1_v, age2_v;
  logic [ADDR_W-1:0] age1_a, age2_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age1_v   <= 1'b0;
      age2_v   <= 1'b0;
      age1_a   <= '0;
      age2_a   <= '0;
      cap_vld  <= 1'b0;
      cap_idx  <= '0;
      cap_data <= '0;
      cap_be   <= '0;
    end else begin
      age1_v   <= (ph == PH_KN) && !wr_sel_n;
      age1_a   <= addr;
      age2_v   <= age1_v;
      age2_a   <= age1_a;
      // Input register: the word on this edge, tagged with its slot.
      cap_vld  <= age1_v | age2_v;
      cap_idx  <= age1_v ? {age1_a, 1'b0} : {age2_a, 1'b1};
      cap_data <= wdata;
      cap_be   <= ~bw_n;
    end
  end

  // R5
  wr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_KN) && !wr_sel_n) |=> ##1
      (cap_vld && !cap_idx[0] && (cap_idx[ADDR_W:1] == $past(addr, 2)))
      ##1 (cap_vld && cap_idx[0] && (cap_idx[ADDR_W:1] == $past(addr, 3))));
endmodule

// File: rtl/qdr2_rd_path.sv
`timescale 1ns/1ps
module qdr2_rd_path
  import qdr2_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  phase_e          ph,
  input  logic [ADDR_W-1:0] addr,
  input  logic            rd_sel_n,
  output logic            rd_fire,
  output logic [ADDR_W:0] rd_idx
);
  localparam int unsigned NST = RD_LAT_EDGES + 1;
  localparam int unsigned W0  = RD_LAT_EDGES - 1;
  localparam int unsigned W1  = RD_LAT_EDGES;

  logic [NST-1:0]    st_v;
  logic [ADDR_W-1:0] st_a [NST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v <= '0;
      for (int i = 0; i < NST; i++) st_a[i] <= '0;
    end else begin
      st_v     <= {st_v[NST-2:0], (ph == PH_K) && !rd_sel_n};
      st_a[0]  <= addr;
      for (int i = 1; i < NST; i++) st_a[i] <= st_a[i-1];
    end
  end

  assign rd_fire = st_v[W0] | st_v[W1];
  assign rd_idx  = st_v[W0] ? {st_a[W0], 1'b0} : {st_a[W1], 1'b1};

  // R7
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_K) && !rd_sel_n) |-> ##3 (rd_fire && !rd_idx[0])
      ##1 (rd_fire && rd_idx[0]));
endmodule

// File: rtl/qdr2_array.sv
`timescale 1ns/1ps
module qdr2_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_vld,
  input  logic [ADDR_W:0]          cap_idx,
  input  logic [DATA_W-1:0]        cap_data,
  input  logic [DATA_W/LANE_W-1:0] cap_be,
  input  logic                     rd_fire,
  input  logic [ADDR_W:0]          rd_idx,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rvalid
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned DEPTH = 1 << (ADDR_W + 1);

  logic [DATA_W-1:0] mem [DEPTH];

  // Commit of the captured word, lane by lane.
  always_ff @(posedge clk) begin
    if (cap_vld) begin
      for (int l = 0; l < LANES; l++) begin
        if (cap_be[l]) mem[cap_idx][l*LANE_W +: LANE_W] <= cap_data[l*LANE_W +: LANE_W];
      end
    end
  end

  // Output register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_fire;
      if (rd_fire) rdata <= mem[rd_idx];
    end
  end
endmodule

// File: rtl/qdr2_burst_sram.sv
`timescale 1ns/1ps
module qdr2_burst_sram
  import qdr2_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic                     k_edge,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rd_sel_n,
  input  logic                     wr_sel_n,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W/LANE_W-1:0] bw_n,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rvalid
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  phase_e            ph;
  logic              cap_vld;
  logic [ADDR_W:0]   cap_idx;
  logic [DATA_W-1:0] cap_data;
  logic [LANES-1:0]  cap_be;
  logic              rd_fire;
  logic [ADDR_W:0]   rd_idx;

  qdr2_phase u_phase (.clk(clk), .rst_n(rst_n), .ph(ph));

  qdr2_wr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .ph(ph), .addr(addr), .wr_sel_n(wr_sel_n),
    .wdata(wdata), .bw_n(bw_n), .cap_vld(cap_vld), .cap_idx(cap_idx),
    .cap_data(cap_data), .cap_be(cap_be)
  );

  qdr2_rd_path #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .ph(ph), .addr(addr), .rd_sel_n(rd_sel_n),
    .rd_fire(rd_fire), .rd_idx(rd_idx)
  );

  qdr2_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .cap_vld(cap_vld), .cap_idx(cap_idx),
    .cap_data(cap_data), .cap_be(cap_be), .rd_fire(rd_fire), .rd_idx(rd_idx),
    .rdata(rdata), .rvalid(rvalid)
  );

  assign k_edge = (ph == PH_K);

  // R7
  out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (k_edge && !rd_sel_n) |-> ##4 rvalid ##1 rvalid);

  // R2
  word0_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> k_edge);
endmodule

// File: tb/qdr2_burst_sram_tb_top.sv
`timescale 1ns/1ps
module qdr2_burst_sram_tb_top;
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int LW    = 4;
  localparam int NL    = DW / LW;
  localparam int DEPTH = 1 << (AW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          k_edge;
  logic [AW-1:0] addr = '0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [NL-1:0] bw_n = '1;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #2.5 clk = ~clk;

  qdr2_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .addr(addr),
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .wdata(wdata), .bw_n(bw_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cur    = 0;
  string cur_tag = "R1";

  logic [DW-1:0] model [DEPTH];
  int            lw_edge = -10;
  logic [AW-1:0] lw_addr = '0;
  int            pr_edge = -10;
  logic [AW-1:0] pr_addr = '0;
  string         pr_tag  = "R7";
  logic [DW-1:0] exp_q [$];
  int            vis_q [$];
  string         tag_q [$];

  bit            pw = 1'b0;
  logic [DW-1:0] pd0, pd1;
  logic [NL-1:0] pb0, pb1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_write(input logic [AW:0] idx, input logic [DW-1:0] d,
                             input logic [NL-1:0] b);
    for (int l = 0; l < NL; l++)
      if (!b[l]) model[idx][l*LW +: LW] = d[l*LW +: LW];
  endtask

  // One edge: check the previous edge's outputs, resolve due reads, drive inputs.
  task automatic do_edge(input logic [AW-1:0] a, input logic rs, input logic ws,
                         input logic [DW-1:0] wd, input logic [NL-1:0] bw);
    if (cur > 0) begin
      if (vis_q.size() > 0 && vis_q[0] == cur - 1) begin
        chk(rvalid == 1'b1, tag_q[0], "rvalid high on burst word", 32'(rvalid), 32'd1);
        chk(rdata == exp_q[0], tag_q[0], "rdata burst word", 32'(rdata), 32'(exp_q[0]));
        void'(vis_q.pop_front());
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end else begin
        chk(rvalid == 1'b0, cur_tag, "rvalid low when no read due", 32'(rvalid), 32'd0);
      end
    end
    // R2: phase flag follows edge parity
    chk(k_edge == ((cur % 2) == 0), "R2", "k_edge parity", 32'(k_edge), 32'((cur % 2) == 0));
    if (pr_edge == cur - 2) begin
      exp_q.push_back(model[{pr_addr, 1'b0}]); vis_q.push_back(pr_edge + 3); tag_q.push_back(pr_tag);
      exp_q.push_back(model[{pr_addr, 1'b1}]); vis_q.push_back(pr_edge + 4); tag_q.push_back(pr_tag);
    end
    addr = a; rd_sel_n = rs; wr_sel_n = ws; wdata = wd; bw_n = bw;
    if (lw_edge == cur - 1) model_write({lw_addr, 1'b0}, wd, bw);
    if (lw_edge == cur - 2) model_write({lw_addr, 1'b1}, wd, bw);
    if ((cur % 2) == 0 && rs == 1'b0) begin pr_edge = cur; pr_addr = a; pr_tag = cur_tag; end
    if ((cur % 2) == 1 && ws == 1'b0) begin lw_edge = cur; lw_addr = a; end
    @(negedge clk);
    cur++;
  endtask

  // One full cycle: K edge (read command, pending word 0), K# edge (write command, pending word 1).
  task automatic cyc(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa,
                     input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                     input logic [NL-1:0] b0, input logic [NL-1:0] b1);
    if ((cur % 2) == 1) do_edge('0, 1'b1, 1'b1, 8'h3C, '0);
    do_edge(ra, !rd, 1'b1, pw ? pd0 : 8'hC3, pw ? pb0 : '0);
    do_edge(wa, 1'b1, !wr, pw ? pd1 : 8'h96, pw ? pb1 : '0);
    pw = wr; pd0 = d0; pd1 = d1; pb0 = b0; pb1 = b1;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) cyc(1'b0, '0, 1'b0, '0, '0, '0, '1, '1);
  endtask

  task automatic t_reset();
    // R1: reset values before and just after release
    chk(rvalid == 1'b0, "R1", "rvalid in reset", 32'(rvalid), 32'd0);
    chk(rdata == '0, "R1", "rdata in reset", 32'(rdata), 32'd0);
    chk(k_edge == 1'b1, "R1", "k_edge in reset", 32'(k_edge), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    chk(rvalid == 1'b0, "R1", "rvalid after release", 32'(rvalid), 32'd0);
    chk(k_edge == 1'b1, "R1", "k_edge after release", 32'(k_edge), 32'd1);
  endtask

  task automatic t_fill();
    cur_tag = "R5";  // R5: both burst words land in their slots
    for (int a = 0; a < DEPTH / 2; a++)
      cyc(1'b0, '0, 1'b1, AW'(a), DW'(a * 5 + 1), DW'(a * 7 + 2), '0, '0);
    drain();
    cyc(1'b1, 6'd0, 1'b0, '0, '0, '0, '1, '1);
    cyc(1'b1, 6'd17, 1'b0, '0, '0, '0, '1, '1);
    cyc(1'b1, 6'd63, 1'b0, '0, '0, '0, '1, '1);
    drain();
  endtask

  task automatic t_mask();
    cur_tag = "R6";  // R6: only lanes with bw_n bit low change
    cyc(1'b0, '0, 1'b1, 6'd9, 8'hAB, 8'hCD, 2'b10, 2'b01);
    cyc(1'b0, '0, 1'b1, 6'd9, 8'hEE, 8'hFF, 2'b11, 2'b11);
    cyc(1'b1, 6'd9, 1'b0, '0, '0, '0, '1, '1);
    drain();
  endtask

  task automatic t_phase();
    cur_tag = "R3";  // R3: read select on a K# edge is not a command
    if ((cur % 2) == 1) do_edge('0, 1'b1, 1'b1, 8'h11, '1);
    do_edge(6'd3, 1'b1, 1'b1, 8'h11, '1);
    do_edge(6'd3, 1'b0, 1'b1, 8'h22, '1);
    drain();
    cur_tag = "R4";  // R4: write select on a K edge is not a command
    do_edge(6'd12, 1'b1, 1'b0, 8'h5F, '0);
    do_edge(6'd12, 1'b1, 1'b1, 8'h6F, '0);
    do_edge(6'd12, 1'b1, 1'b1, 8'h7F, '0);
    do_edge(6'd12, 1'b1, 1'b1, 8'h8F, '0);
    cyc(1'b1, 6'd12, 1'b0, '0, '0, '0, '1, '1);
    drain();
  endtask

  task automatic t_b2b();
    cur_tag = "R8";  // R8: gapless stream for reads on every K edge
    for (int a = 1; a <= 6; a++) cyc(1'b1, AW'(a), 1'b0, '0, '0, '0, '1, '1);
    drain();
  endtask

  task automatic t_raw();
    cur_tag = "R9";  // R9: ordering of a read against neighbouring writes
    cyc(1'b0, '0, 1'b1, 6'd20, 8'h9A, 8'hBC, '0, '0);
    cyc(1'b1, 6'd20, 1'b0, '0, '0, '0, '1, '1);
    cyc(1'b1, 6'd21, 1'b1, 6'd21, 8'h01, 8'h02, '0, '0);
    cyc(1'b1, 6'd21, 1'b0, '0, '0, '0, '1, '1);
    drain();
  endtask

  task automatic t_conc();
    cur_tag = "R10";  // R10: a read and a write every cycle
    for (int i = 0; i < 24; i++)
      cyc(1'b1, AW'($urandom()), 1'b1, AW'($urandom()), DW'($urandom()), DW'($urandom()),
          NL'($urandom()), NL'($urandom()));
    drain();
  endtask

  task automatic t_idle();
    cur_tag = "R11";  // R11: junk data with no select leaves memory unchanged
    for (int i = 0; i < 6; i++) cyc(1'b0, AW'(i), 1'b0, AW'(i + 30), '0, '0, '0, '0);
    cyc(1'b1, 6'd30, 1'b0, '0, '0, '0, '1, '1);
    cyc(1'b1, 6'd33, 1'b0, '0, '0, '0, '1, '1);
    drain();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_fill();
    t_mask();
    t_phase();
    t_b2b();
    t_raw();
    t_conc();
    t_idle();
    // R7: every expected burst word was observed in time
    chk(vis_q.size() == 0, "R7", "no outstanding read words", 32'(vis_q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule